// File: doc/BRIEF.md
# Serial Register-File Slave Interface

This block is a synchronous serial slave that lets a host reach a sparse bank of twelve registers over a four-wire link made of a chip select, a serial clock, serial data in and serial data out. Each transaction opens with a command byte. The byte holds a start bit, a read/write flag and a 5-bit register address. A data phase follows, and its length is 8 or 16 bits, taken from the width of the addressed register. The host can run several transactions back to back while chip select stays low.

All serial inputs are brought into the system clock domain and oversampled. The block samples data in on the rising edge of the serial clock and changes data out on the falling edge. On the core side, a completed write to a writable register produces a single-cycle strobe that carries the address and the assembled data. For a read, the block puts the register address on a lookup port and shifts out the value that the core returns.

Two faults leave the interface locked: chip select rising in the middle of a transfer, or any other loss of bit alignment. A locked interface ignores all traffic until the host clocks in 32 consecutive zero bits with chip select low.

Top module: `ssr_slave`

## Requirements
- R1: While reset is asserted and after it is released, sdo_oe and wr_stb are 0 and no write strobe has been issued.
- R2: A command begins with the first 1 bit received in the idle state. Any 0 bits before it are discarded. The next bit is the direction flag (1 = read). The five bits after that are the address, MSB first. The last bit of the command byte is ignored.
- R3: A write to a 16-bit writable address (0x01, 0x02, 0x03, 0x04, 0x05, 0x07, 0x09) takes 16 data bits, MSB first. It then gives exactly one wr_stb pulse, one system clock long, with wr_addr equal to the address and wr_data equal to the 16 bits.
- R4: Address 0x06 is writable and 8 bits wide. A write to it takes 8 data bits, and the strobe carries them in wr_data[7:0] with wr_data[15:8] equal to 0.
- R5: A write to a read-only address (0x00, 0x08, 0x0A, 0x14) or to a reserved address still takes a data phase of that address's width: 8 bits for 0x00 and 0x14, 16 bits for all others. It gives no strobe.
- R6: A read puts the address on rd_addr and shifts out rd_data MSB first, changing sdo after each falling serial clock edge. For the 16-bit readable addresses all 16 bits are sent. For the 8-bit addresses 0x00, 0x06 and 0x14, bits 7 down to 0 are sent.
- R7: A read of a reserved address (any address other than the twelve named in R3 to R5) has a 16-bit data phase and returns all zeros.
- R8: sdo_oe is 1 only during the data phase of a read. It is 0 during commands, during writes and between transactions.
- R9: Transactions can follow each other without chip select going high, and each one starts with its own command byte.
- R10: If chip select rises during a command or a data phase, the interface locks. While locked it issues no strobes and never drives sdo_oe. After 32 consecutive 0 bits clocked in with chip select low, it accepts a new command.
- R11: A run of 31 consecutive zeros does not unlock a locked interface.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low, asynchronous to clk |
| sclk | input | 1 | Serial clock from the host, idles low |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial data to the host |
| sdo_oe | output | 1 | Output enable for sdo (1 = drive, 0 = high impedance) |
| wr_stb | output | 1 | Single-cycle write strobe to the core |
| wr_addr | output | 5 | Address carried with the write strobe |
| wr_data | output | 16 | Data carried with the write strobe |
| rd_addr | output | 5 | Address of the register being read |
| rd_data | input | 16 | Read-back value from the core for rd_addr |

## Verification
The hardest state to reach from the ports is the locked state. The bench gets there by starting a read and raising chip select four bits into its data phase. It then checks that a full write and a full read produce no strobe and no output enable. Next it sends a 1 followed by exactly 31 zeros and confirms the interface is still locked. Finally it sends 32 zeros and confirms that a write goes through again. To check that each address consumes the right data-phase length, the bench sweeps all 32 addresses, each as a write followed at once by a read under the same chip select. If any data phase had the wrong length, the read that follows would be misaligned and would return the wrong value.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
  parameter int unsigned ADDR_W  = 5;
  parameter int unsigned DATA_W  = 16;
  parameter int unsigned SHORT_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CMD  = 2'd1,
    ST_DATA = 2'd2,
    ST_LOCK = 2'd3
  } ssr_state_e;

  typedef struct packed {
    logic valid;
    logic writable;
    logic short_w;
  } reg_attr_t;

  function automatic reg_attr_t reg_attr(input logic [ADDR_W-1:0] a);
    reg_attr_t r;
    r = '0;
    case (a)
      5'h00: r = '{valid: 1'b1, writable: 1'b0, short_w: 1'b1};
      5'h01, 5'h02, 5'h03, 5'h04, 5'h05, 5'h07, 5'h09:
             r = '{valid: 1'b1, writable: 1'b1, short_w: 1'b0};
      5'h06: r = '{valid: 1'b1, writable: 1'b1, short_w: 1'b1};
      5'h08, 5'h0A:
             r = '{valid: 1'b1, writable: 1'b0, short_w: 1'b0};
      5'h14: r = '{valid: 1'b1, writable: 1'b0, short_w: 1'b1};
      default: r = '0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/ssr_sync.sv
module ssr_sync #(
  parameter int unsigned WIDTH     = 3,
  parameter int unsigned STAGES    = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= {STAGES{RESET_VAL[i]}};
      else     chain <= {chain[STAGES-2:0], d[i]};
    end
    assign q[i] = chain[STAGES-1];
  end
endmodule

// File: rtl/ssr_decode.sv
module ssr_decode
  import ssr_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output reg_attr_t         attr,
  output logic [DATA_W-1:0] mask
);
  localparam logic [DATA_W-1:0] SHORT_MASK = DATA_W'((1 << SHORT_W) - 1);

  always_comb begin
    attr = reg_attr(addr);
    if (!attr.valid)       mask = '0;
    else if (attr.short_w) mask = SHORT_MASK;
    else                   mask = '1;
  end
endmodule

// File: rtl/ssr_engine.sv
module ssr_engine
  import ssr_pkg::*;
#(
  parameter int unsigned RESYNC_ZEROS = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n_s,
  input  logic              sclk_s,
  input  logic              sdi_s,
  input  reg_attr_t         cmd_attr,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  input  logic [DATA_W-1:0] rd_mask,
  output logic              sdo,
  output logic              sdo_oe
);
  localparam int unsigned CMD_TAIL = ADDR_W + 1;
  localparam int unsigned CW       = $clog2(CMD_TAIL + 1);
  localparam int unsigned IW       = $clog2(DATA_W);
  localparam int unsigned ZW       = $clog2(RESYNC_ZEROS);

  ssr_state_e        state;
  logic              sclk_q;
  logic [CW-1:0]     cmd_cnt;
  logic [ADDR_W:0]   cmd_sr;
  logic              is_rd, cur_wr, cur_short, first;
  logic [IW-1:0]     bitidx;
  logic [DATA_W-1:0] wsr, rbuf;
  logic [ZW-1:0]     zcnt;
  logic              rise, fall;

  assign rise     = sclk_s & ~sclk_q & ~cs_n_s;
  assign fall     = ~sclk_s & sclk_q & ~cs_n_s;
  assign cmd_addr = cmd_sr[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      sclk_q    <= 1'b0;
      cmd_cnt   <= '0;
      cmd_sr    <= '0;
      is_rd     <= 1'b0;
      cur_wr    <= 1'b0;
      cur_short <= 1'b0;
      first     <= 1'b0;
      bitidx    <= '0;
      wsr       <= '0;
      rbuf      <= '0;
      zcnt      <= '0;
      wr_stb    <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      rd_addr   <= '0;
      sdo       <= 1'b0;
      sdo_oe    <= 1'b0;
    end else begin
      sclk_q <= sclk_s;
      wr_stb <= 1'b0;
      if (cs_n_s) begin
        zcnt   <= '0;
        sdo_oe <= 1'b0;
        if (state == ST_CMD || state == ST_DATA) state <= ST_LOCK;
      end else if (rise) begin
        if (sdi_s) zcnt <= '0;
        else if (zcnt == ZW'(RESYNC_ZEROS - 1)) zcnt <= '0;
        else zcnt <= zcnt + 1'b1;
        if (!sdi_s && zcnt == ZW'(RESYNC_ZEROS - 1)) begin
          state  <= ST_IDLE;
          sdo_oe <= 1'b0;
        end else begin
          case (state)
            ST_IDLE: begin
              if (sdi_s) begin
                state   <= ST_CMD;
                cmd_cnt <= '0;
              end
            end
            ST_CMD: begin
              cmd_sr <= {cmd_sr[ADDR_W-1:0], sdi_s};
              if (cmd_cnt == CW'(CMD_TAIL)) begin
                state     <= ST_DATA;
                is_rd     <= cmd_sr[ADDR_W];
                cur_wr    <= cmd_attr.writable & ~cmd_sr[ADDR_W];
                cur_short <= cmd_attr.short_w;
                bitidx    <= cmd_attr.short_w ? IW'(SHORT_W - 1) : IW'(DATA_W - 1);
                rd_addr   <= cmd_sr[ADDR_W-1:0];
                first     <= 1'b1;
              end else begin
                cmd_cnt <= cmd_cnt + 1'b1;
              end
            end
            ST_DATA: begin
              wsr <= {wsr[DATA_W-2:0], sdi_s};
              if (bitidx == '0) begin
                state  <= ST_IDLE;
                sdo_oe <= 1'b0;
                if (cur_wr) begin
                  wr_stb  <= 1'b1;
                  wr_addr <= rd_addr;
                  wr_data <= cur_short
                           ? {{(DATA_W-SHORT_W){1'b0}}, wsr[SHORT_W-2:0], sdi_s}
                           : {wsr[DATA_W-2:0], sdi_s};
                end
              end else begin
                bitidx <= bitidx - 1'b1;
              end
            end
            default: ;
          endcase
        end
      end else if (fall && state == ST_DATA && is_rd) begin
        if (first) begin
          rbuf   <= rd_data & rd_mask;
          sdo    <= rd_data[bitidx] & rd_mask[bitidx];
          sdo_oe <= 1'b1;
          first  <= 1'b0;
        end else begin
          sdo <= rbuf[bitidx];
        end
      end
    end
  end

  AST_STB_PULSE: assert property (@(posedge clk) disable iff (rst)
    wr_stb |=> !wr_stb); // R3
  AST_STB_WRITABLE: assert property (@(posedge clk) disable iff (rst)
    wr_stb |-> reg_attr(wr_addr).writable); // R5
  AST_OE_READ_PHASE: assert property (@(posedge clk) disable iff (rst)
    sdo_oe |-> (state == ST_DATA && is_rd)); // R8
  AST_OE_CS_HIGH: assert property (@(posedge clk) disable iff (rst)
    (cs_n_s && $past(cs_n_s)) |-> !sdo_oe); // R10
  AST_LOCK_SILENT: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LOCK) |-> (!sdo_oe && !wr_stb)); // R10
  AST_SHORT_IDX: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DATA && cur_short) |-> (bitidx < IW'(SHORT_W))); // R4
endmodule

// File: rtl/ssr_slave.sv
module ssr_slave
  import ssr_pkg::*;
#(
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned RESYNC_ZEROS = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdi,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data
);
  logic [2:0]        pins_s;
  logic [ADDR_W-1:0] cmd_addr;
  reg_attr_t         cmd_attr, rd_attr;
  logic [DATA_W-1:0] cmd_mask, rd_mask;

  ssr_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RESET_VAL(3'b100)) u_sync (
    .clk(clk), .rst(rst), .d({cs_n, sclk, sdi}), .q(pins_s)
  );

  ssr_decode u_cmd_dec (.addr(cmd_addr), .attr(cmd_attr), .mask(cmd_mask));
  ssr_decode u_rd_dec  (.addr(rd_addr),  .attr(rd_attr),  .mask(rd_mask));

  ssr_engine #(.RESYNC_ZEROS(RESYNC_ZEROS)) u_engine (
    .clk(clk), .rst(rst),
    .cs_n_s(pins_s[2]), .sclk_s(pins_s[1]), .sdi_s(pins_s[0]),
    .cmd_attr(cmd_attr), .cmd_addr(cmd_addr),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .rd_mask(rd_mask),
    .sdo(sdo), .sdo_oe(sdo_oe)
  );
endmodule

// File: tb/tb_ssr_slave.sv
module tb_ssr_slave;
  logic clk, rst, cs_n, sclk, sdi;
  logic sdo, sdo_oe, wr_stb;
  logic [4:0] wr_addr, rd_addr;
  logic [15:0] wr_data, rd_data;

  int checks = 0, errors = 0;
  int stb_n = 0, oe_n = 0;
  logic [4:0] cap_a;
  logic [15:0] cap_d;
  logic last_o, last_oe;
  bit done = 0;

  ssr_slave dut (.clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data));

  initial clk = 0;
  always #10 clk = ~clk;

  function automatic logic [15:0] model(input logic [4:0] a);
    return {a, 3'b101, ~a, 3'b011};
  endfunction
  assign rd_data = model(rd_addr);

  function automatic bit is_valid(input logic [4:0] a);
    return (a <= 5'h0A) || (a == 5'h14);
  endfunction
  function automatic bit is_wr(input logic [4:0] a);
    return (a >= 5'h01 && a <= 5'h07) || (a == 5'h09);
  endfunction
  function automatic int width(input logic [4:0] a);
    return (a == 5'h00 || a == 5'h06 || a == 5'h14) ? 8 : 16;
  endfunction

  always @(posedge clk) begin
    if (wr_stb) begin stb_n <= stb_n + 1; cap_a <= wr_addr; cap_d <= wr_data; end
    if (sdo_oe) oe_n <= oe_n + 1;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic sbit(input logic b);
    sdi = b; #200;
    last_o = sdo; last_oe = sdo_oe;
    sclk = 1; #200; sclk = 0;
  endtask

  task automatic send_cmd(input logic rw, input logic [4:0] a, input logic ign);
    sbit(1'b1); sbit(rw);
    for (int i = 4; i >= 0; i--) sbit(a[i]);
    sbit(ign);
  endtask

  task automatic write_tx(input logic [4:0] a, input logic [15:0] d, input logic ign);
    int w;
    w = width(a);
    send_cmd(1'b0, a, ign);
    for (int i = w - 1; i >= 0; i--) sbit(d[i]);
    #400;
  endtask

  task automatic read_tx(input logic [4:0] a, output logic [15:0] v, output bit oe_ok);
    int w;
    w = width(a);
    send_cmd(1'b1, a, 1'b0);
    v = '0; oe_ok = 1;
    for (int i = 0; i < w; i++) begin
      sbit(1'b0);
      v = {v[14:0], last_o};
      if (!last_oe) oe_ok = 0;
    end
    #400;
  endtask

  task automatic zeros(input int n);
    for (int i = 0; i < n; i++) sbit(1'b0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, d, m;
    bit oe_ok;
    int s0, o0;
    rst = 1; cs_n = 1; sclk = 0; sdi = 0;
    repeat (5) @(posedge clk);
    #3;
    chk(sdo_oe == 0, "R1 oe in reset", sdo_oe, 0);
    chk(wr_stb == 0, "R1 stb in reset", wr_stb, 0);
    rst = 0;
    #400;
    chk(sdo_oe == 0 && wr_stb == 0 && stb_n == 0, "R1 after reset", stb_n, 0);

    // R2: leading zeros discarded, ignored final command bit set to 1
    cs_n = 0; #200;
    zeros(5);
    s0 = stb_n;
    write_tx(5'h02, 16'hC3A5, 1'b1);
    chk(stb_n == s0 + 1, "R2 strobe count", stb_n - s0, 1);
    chk(cap_a == 5'h02 && cap_d == 16'hC3A5, "R2 addr/data", {cap_a, cap_d}, {5'h02, 16'hC3A5});
    read_tx(5'h02, v, oe_ok);
    chk(v == model(5'h02), "R2 read after leading zeros", v, model(5'h02));

    // R3..R9: sweep all addresses, write then read back to back
    for (int a = 0; a < 32; a++) begin
      d = 16'(a * 1234 + 16'h05A5);
      m = (width(5'(a)) == 8) ? 16'h00FF : 16'hFFFF;
      s0 = stb_n; o0 = oe_n;
      write_tx(5'(a), d, 1'b0);
      if (is_wr(5'(a))) begin
        chk(stb_n == s0 + 1, width(5'(a)) == 8 ? "R4 strobe" : "R3 strobe", stb_n - s0, 1);
        chk(cap_a == 5'(a), "R3 wr_addr", cap_a, a);
        chk(cap_d == (d & m), width(5'(a)) == 8 ? "R4 wr_data" : "R3 wr_data", cap_d, d & m);
      end else begin
        chk(stb_n == s0, "R5 no strobe", stb_n - s0, 0);
      end
      chk(oe_n == o0, "R8 oe idle in write", oe_n - o0, 0);
      read_tx(5'(a), v, oe_ok);
      chk(rd_addr == 5'(a), "R6 rd_addr", rd_addr, a);
      if (is_valid(5'(a)))
        chk(v == (model(5'(a)) & m), "R6/R9 read data", v, model(5'(a)) & m);
      else
        chk(v == 16'h0000, "R7 reserved read", v, 0);
      chk(oe_ok, "R8 oe during read", oe_ok, 1);
      chk(sdo_oe == 0, "R8 oe after read", sdo_oe, 0);
    end
    cs_n = 1; #400;

    // R10: abort mid read, lock
    cs_n = 0; #200;
    send_cmd(1'b1, 5'h01, 1'b0);
    sbit(1'b0); sbit(1'b0); sbit(1'b0); sbit(1'b0);
    cs_n = 1; #400;
    chk(sdo_oe == 0, "R10 oe after abort", sdo_oe, 0);
    cs_n = 0; #200;
    s0 = stb_n; o0 = oe_n;
    write_tx(5'h03, 16'hFFFF, 1'b1);
    chk(stb_n == s0, "R10 locked write ignored", stb_n - s0, 0);
    read_tx(5'h03, v, oe_ok);
    chk(oe_n == o0, "R10 locked read no oe", oe_n - o0, 0);
    // R11: 31 zeros do not unlock
    sbit(1'b1);
    zeros(31);
    s0 = stb_n;
    write_tx(5'h04, 16'hFFFF, 1'b1);
    chk(stb_n == s0, "R11 still locked after 31 zeros", stb_n - s0, 0);
    // R10: 32 zeros unlock
    sbit(1'b1);
    zeros(32);
    s0 = stb_n;
    write_tx(5'h04, 16'h1234, 1'b0);
    chk(stb_n == s0 + 1, "R10 unlocked strobe", stb_n - s0, 1);
    chk(cap_a == 5'h04 && cap_d == 16'h1234, "R10 unlocked data", cap_d, 16'h1234);
    read_tx(5'h09, v, oe_ok);
    chk(v == model(5'h09) && oe_ok, "R10 unlocked read", v, model(5'h09));
    cs_n = 1; #400;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule